// File: doc/BRIEF.md
# Operand Address Sequencer for a Two-Operand Accumulator Core

This block sequences operand fetch for a 16-bit core whose instructions name a source and a destination, where the destination is also read as the second source. Either operand may sit in a register or in memory. When the core's decoder presents a source mode, a destination mode and two register indices with a one-cycle `start`, the sequencer pulls any extension words it needs from the instruction stream. It forms effective addresses and reads memory operands. For the post-increment pointer mode it writes the bumped pointer back. It then raises `done` for one cycle with both operand values and the destination address ready for the execute stage.

The number of cycles between `start` and `done` depends only on the mode pair and on how long the instruction stream takes to supply words. Register 0 is the program counter. When `start` is accepted, it must hold the address of the first extension word. Register 1 is the stack pointer and register 2 the status word, and both are ordinary base registers here. The caller supplies the register file as one flat vector, entry i at bits [16*i+15:16*i]. Memory reads are combinational: `mem_rdata` must answer `mem_addr` in the same cycle.

Top module: `opseq_sequencer`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released, the block is idle: `busy`, `done`, `ext_req`, `mem_rd` and `reg_wr` are 0, and the operand outputs are 0.
- R2: Source modes are encoded as 0 register, 1 indexed, 2 symbolic, 3 absolute, 4 pointer, 5 pointer with post-increment, 6 immediate, and 7 behaves as register. Indexed reads memory at Rs+X, symbolic at PC+X, and absolute at X, where X is the next extension word. PC is register 0 as sampled at `start`, plus 2 for every extension word already taken by this operation.
- R3: Modes 4 and 5 read memory at Rs without an extension word. Mode 5 also drives `reg_wr` for exactly one cycle, in the cycle of the operand read, with index Rs and data Rs+2. No other mode writes a register.
- R4: Immediate mode takes the next extension word itself as the source value and performs no memory read for the source.
- R5: Destination modes are encoded as 0 register, 1 indexed, 2 symbolic, 3 absolute, with the same address rules as R2. A register destination gives `dst_mem`=0, `dst_addr`=0 and `dst_val`=Rd. A memory destination gives `dst_mem`=1, `dst_addr` equal to the effective address, and `dst_val` equal to the memory word read there.
- R6: When both operands need an extension word, the first word taken goes to the source and the second to the destination.
- R7: With extension words granted at once, the latency in cycles from the edge that accepts `start` to the cycle where `done` is high is 1 + s + d. Here s is 0 for register, 1 for modes 4 to 6 and 2 for modes 1 to 3, and d is 0 for a register destination and 3 for a memory destination. So memory to memory takes 6, register to memory 4, and memory to register 3. A memory read and an extension request are never made in the same cycle.
- R8: `ext_req` stays high until `ext_ack`, and every cycle without the grant adds one cycle to the latency.
- R9: `done` is high for exactly one cycle, never while `busy`, and the operand outputs keep their values after `done` until the next operation.
- R10: A `start` that arrives while the block is busy is ignored and does not change the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand sequence when idle |
| src_mode | input | 3 | Source addressing mode code |
| src_reg | input | 4 | Source register index |
| dst_mode | input | 2 | Destination addressing mode code |
| dst_reg | input | 4 | Destination register index |
| reg_file | input | 256 | All register values, entry i at bits 16*i+15:16*i |
| ext_req | output | 1 | Request for the next instruction-stream word |
| ext_ack | input | 1 | Extension word granted this cycle |
| ext_word | input | 16 | Extension word, valid with ext_ack |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, same cycle |
| reg_wr | output | 1 | Pointer write-back strobe |
| reg_wr_idx | output | 4 | Pointer write-back index |
| reg_wr_data | output | 16 | Pointer write-back value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| src_val | output | 16 | Source operand value |
| dst_val | output | 16 | Destination operand value |
| dst_addr | output | 16 | Destination effective address |
| dst_mem | output | 1 | Destination is in memory |

## Verification
The bench walks all 28 pairs of source and destination modes and compares each latency against the cost formula. An off-by-one state, or a read that needs a second cycle, shows up there as a wrong count. Two different extension words are offered back to back, so a sequencer that gives the destination word to the source, or that forgets to advance PC after the first word, reads the wrong address in symbolic mode. The post-increment mode is checked for a single write-back of the right value, and the other modes for no write at all. Stalled grants and a second `start` arriving mid-sequence would expose a block that drops its request or restarts.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    typedef enum logic [2:0] {
        SM_REG  = 3'd0,
        SM_IDX  = 3'd1,
        SM_SYM  = 3'd2,
        SM_ABS  = 3'd3,
        SM_PTR  = 3'd4,
        SM_PINC = 3'd5,
        SM_IMM  = 3'd6,
        SM_RSV  = 3'd7
    } src_mode_e;

    typedef enum logic [1:0] {
        DM_REG = 2'd0,
        DM_IDX = 2'd1,
        DM_SYM = 2'd2,
        DM_ABS = 2'd3
    } dst_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEC  = 3'd1,
        ST_SEXT = 3'd2,
        ST_SRD  = 3'd3,
        ST_DEXT = 3'd4,
        ST_DRD  = 3'd5,
        ST_DWR  = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        EA_BASE_ONLY = 2'd0,
        EA_BASE_OFS  = 2'd1,
        EA_PC_OFS    = 2'd2,
        EA_DIRECT    = 2'd3
    } ea_kind_e;

endpackage

// File: rtl/opseq_mode_decode.sv
module opseq_mode_decode
    import opseq_pkg::*;
(
    input  logic [2:0] src_mode,
    input  logic [1:0] dst_mode,
    output logic       src_is_reg,
    output logic       src_ext,
    output logic       src_ptr,
    output logic       src_imm,
    output logic       src_inc,
    output ea_kind_e   src_kind,
    output logic       dst_is_mem,
    output ea_kind_e   dst_kind
);

    always_comb begin
        src_is_reg = 1'b0;
        src_ext    = 1'b0;
        src_ptr    = 1'b0;
        src_imm    = 1'b0;
        src_inc    = 1'b0;
        src_kind   = EA_BASE_ONLY;
        case (src_mode)
            SM_IDX: begin
                src_ext  = 1'b1;
                src_kind = EA_BASE_OFS;
            end
            SM_SYM: begin
                src_ext  = 1'b1;
                src_kind = EA_PC_OFS;
            end
            SM_ABS: begin
                src_ext  = 1'b1;
                src_kind = EA_DIRECT;
            end
            SM_PTR: src_ptr = 1'b1;
            SM_PINC: begin
                src_ptr = 1'b1;
                src_inc = 1'b1;
            end
            SM_IMM: begin
                src_ext = 1'b1;
                src_imm = 1'b1;
            end
            default: src_is_reg = 1'b1;
        endcase
    end

    always_comb begin
        dst_is_mem = (dst_mode != DM_REG);
        case (dst_mode)
            DM_IDX:  dst_kind = EA_BASE_OFS;
            DM_SYM:  dst_kind = EA_PC_OFS;
            DM_ABS:  dst_kind = EA_DIRECT;
            default: dst_kind = EA_BASE_ONLY;
        endcase
    end

endmodule

// File: rtl/opseq_ea_calc.sv
module opseq_ea_calc
    import opseq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  ea_kind_e          kind,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] ofs,
    output logic [WORD_W-1:0] ea
);

    always_comb begin
        case (kind)
            EA_BASE_OFS: ea = base + ofs;
            EA_PC_OFS:   ea = pc + ofs;
            EA_DIRECT:   ea = ofs;
            default:     ea = base;
        endcase
    end

endmodule

// File: rtl/opseq_reg_pick.sv
module opseq_reg_pick #(
    parameter int WORD_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*WORD_W-1:0] bank_flat,
    input  logic [RIDX_W-1:0]          idx,
    output logic [WORD_W-1:0]          value
);

    logic [WORD_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign bank[g] = bank_flat[g*WORD_W +: WORD_W];
    end

    assign value = bank[idx];

endmodule

// File: rtl/opseq_sequencer.sv
module opseq_sequencer
    import opseq_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 src_mode,
    input  logic [RIDX_W-1:0]          src_reg,
    input  logic [1:0]                 dst_mode,
    input  logic [RIDX_W-1:0]          dst_reg,
    input  logic [NUM_REGS*WORD_W-1:0] reg_file,
    output logic                       ext_req,
    input  logic                       ext_ack,
    input  logic [WORD_W-1:0]          ext_word,
    output logic                       mem_rd,
    output logic [WORD_W-1:0]          mem_addr,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic                       reg_wr,
    output logic [RIDX_W-1:0]          reg_wr_idx,
    output logic [WORD_W-1:0]          reg_wr_data,
    output logic                       busy,
    output logic                       done,
    output logic [WORD_W-1:0]          src_val,
    output logic [WORD_W-1:0]          dst_val,
    output logic [WORD_W-1:0]          dst_addr,
    output logic                       dst_mem
);

    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    typedef struct packed {
        seq_state_e        state;
        logic [2:0]        smode;
        logic [1:0]        dmode;
        logic [RIDX_W-1:0] sreg;
        logic [RIDX_W-1:0] dreg;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] src_ea;
        logic [WORD_W-1:0] dst_ea;
        logic [WORD_W-1:0] src_val;
        logic [WORD_W-1:0] dst_val;
        logic [WORD_W-1:0] dst_addr;
        logic              dst_mem;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              s_is_reg, s_ext, s_ptr, s_imm, s_inc, d_is_mem;
    ea_kind_e          s_kind, d_kind;
    logic [WORD_W-1:0] src_rval, dst_rval, r0_val;
    logic [WORD_W-1:0] src_ea_c, dst_ea_c;
    logic              to_dst;

    assign r0_val = reg_file[WORD_W-1:0];

    opseq_mode_decode u_dec (
        .src_mode   (seq_q.smode),
        .dst_mode   (seq_q.dmode),
        .src_is_reg (s_is_reg),
        .src_ext    (s_ext),
        .src_ptr    (s_ptr),
        .src_imm    (s_imm),
        .src_inc    (s_inc),
        .src_kind   (s_kind),
        .dst_is_mem (d_is_mem),
        .dst_kind   (d_kind)
    );

    opseq_reg_pick #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .RIDX_W(RIDX_W)) u_pick_src (
        .bank_flat (reg_file),
        .idx       (seq_q.sreg),
        .value     (src_rval)
    );

    opseq_reg_pick #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .RIDX_W(RIDX_W)) u_pick_dst (
        .bank_flat (reg_file),
        .idx       (seq_q.dreg),
        .value     (dst_rval)
    );

    opseq_ea_calc #(.WORD_W(WORD_W)) u_ea_src (
        .kind (s_kind),
        .base (src_rval),
        .pc   (seq_q.pc),
        .ofs  (ext_word),
        .ea   (src_ea_c)
    );

    opseq_ea_calc #(.WORD_W(WORD_W)) u_ea_dst (
        .kind (d_kind),
        .base (dst_rval),
        .pc   (seq_q.pc),
        .ofs  (ext_word),
        .ea   (dst_ea_c)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        ext_req     = 1'b0;
        mem_rd      = 1'b0;
        mem_addr    = '0;
        reg_wr      = 1'b0;
        reg_wr_idx  = seq_q.sreg;
        reg_wr_data = src_rval + STEP;
        to_dst      = 1'b0;

        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_DEC;
                    seq_d.smode = src_mode;
                    seq_d.dmode = dst_mode;
                    seq_d.sreg  = src_reg;
                    seq_d.dreg  = dst_reg;
                    seq_d.pc    = r0_val;
                end
            end
            ST_DEC: begin
                if (s_is_reg) begin
                    seq_d.src_val = src_rval;
                end
                if (s_ext) begin
                    seq_d.state = ST_SEXT;
                end else if (s_ptr) begin
                    seq_d.state = ST_SRD;
                end else begin
                    to_dst = 1'b1;
                end
            end
            ST_SEXT: begin
                ext_req = 1'b1;
                if (ext_ack) begin
                    seq_d.pc = seq_q.pc + STEP;
                    if (s_imm) begin
                        seq_d.src_val = ext_word;
                        to_dst        = 1'b1;
                    end else begin
                        seq_d.src_ea = src_ea_c;
                        seq_d.state  = ST_SRD;
                    end
                end
            end
            ST_SRD: begin
                mem_rd        = 1'b1;
                mem_addr      = s_ptr ? src_rval : seq_q.src_ea;
                seq_d.src_val = mem_rdata;
                reg_wr        = s_inc;
                to_dst        = 1'b1;
            end
            ST_DEXT: begin
                ext_req = 1'b1;
                if (ext_ack) begin
                    seq_d.pc     = seq_q.pc + STEP;
                    seq_d.dst_ea = dst_ea_c;
                    seq_d.state  = ST_DRD;
                end
            end
            ST_DRD: begin
                mem_rd        = 1'b1;
                mem_addr      = seq_q.dst_ea;
                seq_d.dst_val = mem_rdata;
                seq_d.state   = ST_DWR;
            end
            ST_DWR: begin
                seq_d.state    = ST_IDLE;
                seq_d.done     = 1'b1;
                seq_d.dst_addr = seq_q.dst_ea;
                seq_d.dst_mem  = 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase

        if (to_dst) begin
            if (d_is_mem) begin
                seq_d.state = ST_DEXT;
            end else begin
                seq_d.state    = ST_IDLE;
                seq_d.done     = 1'b1;
                seq_d.dst_val  = dst_rval;
                seq_d.dst_addr = '0;
                seq_d.dst_mem  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.state != ST_IDLE);
    assign done     = seq_q.done;
    assign src_val  = seq_q.src_val;
    assign dst_val  = seq_q.dst_val;
    assign dst_addr = seq_q.dst_addr;
    assign dst_mem  = seq_q.dst_mem;

endmodule

// File: rtl/opseq_sequencer_chk.sv
module opseq_sequencer_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ext_req,
    input logic              ext_ack,
    input logic              mem_rd,
    input logic [WORD_W-1:0] mem_addr,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wr_data,
    input logic              dst_mem,
    input logic [WORD_W-1:0] dst_addr
);

    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> ext_req);

    assert_inc_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (mem_rd && (reg_wr_data == mem_addr + STEP)));

    assert_one_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && ext_req));

    assert_reg_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dst_mem) |-> (dst_addr == '0));

endmodule

bind opseq_sequencer opseq_sequencer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .ext_req     (ext_req),
    .ext_ack     (ext_ack),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .reg_wr      (reg_wr),
    .reg_wr_data (reg_wr_data),
    .dst_mem     (dst_mem),
    .dst_addr    (dst_addr)
);

// File: tb/opseq_sequencer_test.sv
module opseq_sequencer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  src_mode = '0;
    logic [3:0]  src_reg = '0;
    logic [1:0]  dst_mode = '0;
    logic [3:0]  dst_reg = '0;
    logic [255:0] reg_file;
    logic        ext_req, ext_ack;
    logic [15:0] ext_word;
    logic        mem_rd;
    logic [15:0] mem_addr, mem_rdata;
    logic        reg_wr;
    logic [3:0]  reg_wr_idx;
    logic [15:0] reg_wr_data;
    logic        busy, done;
    logic [15:0] src_val, dst_val, dst_addr;
    logic        dst_mem;

    logic [15:0] regs [16];
    logic [15:0] ext_words [256];
    logic [7:0]  ext_idx;
    int          wait_cnt;
    int          stall_req = 0;
    int          wr_count;
    logic [3:0]  wr_idx_seen;
    logic [15:0] wr_data_seen;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++) reg_file[i*16 +: 16] = regs[i];
    end

    assign mem_rdata = memf(mem_addr);
    assign ext_ack   = ext_req && (wait_cnt >= stall_req);
    assign ext_word  = ext_words[ext_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            ext_idx  <= '0;
            wait_cnt <= 0;
            wr_count <= 0;
        end else begin
            if (ext_req) begin
                if (ext_ack) begin
                    ext_idx  <= ext_idx + 8'd1;
                    wait_cnt <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
            if (reg_wr) begin
                wr_count     <= wr_count + 1;
                wr_idx_seen  <= reg_wr_idx;
                wr_data_seen <= reg_wr_data;
            end
        end
    end

    opseq_sequencer uut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .src_mode (src_mode), .src_reg (src_reg),
        .dst_mode (dst_mode), .dst_reg (dst_reg),
        .reg_file (reg_file),
        .ext_req (ext_req), .ext_ack (ext_ack), .ext_word (ext_word),
        .mem_rd (mem_rd), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
        .reg_wr (reg_wr), .reg_wr_idx (reg_wr_idx), .reg_wr_data (reg_wr_data),
        .busy (busy), .done (done),
        .src_val (src_val), .dst_val (dst_val),
        .dst_addr (dst_addr), .dst_mem (dst_mem)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_regs(input int seed);
        for (int i = 1; i < 16; i++) regs[i] = 16'h0200 + 16'(i * 'h22) + 16'(seed * 'h13);
        regs[0] = 16'hF000 + 16'(seed * 4);
    endtask

    task automatic run_op(input logic [2:0] sm, input logic [3:0] sr,
                          input logic [1:0] dm, input logic [3:0] dr,
                          input logic [15:0] x1, input logic [15:0] x2,
                          input int stall, input bit glitch);
        logic [15:0] pc, ea, sv, dv, da, xd;
        int fetch, cs, cd, lat, n, wr0;
        bit dm_exp;
        string stag;
        ext_words[ext_idx]        = x1;
        ext_words[ext_idx + 8'd1] = x2;
        stall_req = stall;
        wr0 = wr_count;
        pc = regs[0];
        fetch = 0;
        stag = "R2";
        case (sm)
            3'd1: begin ea = regs[sr] + x1; sv = memf(ea); fetch = 1; cs = 2; end
            3'd2: begin ea = pc + x1; sv = memf(ea); fetch = 1; cs = 2; end
            3'd3: begin sv = memf(x1); fetch = 1; cs = 2; end
            3'd4, 3'd5: begin sv = memf(regs[sr]); cs = 1; stag = "R3"; end
            3'd6: begin sv = x1; fetch = 1; cs = 1; stag = "R4"; end
            default: begin sv = regs[sr]; cs = 0; end
        endcase
        pc = pc + 16'(2 * fetch);
        xd = (fetch == 1) ? x2 : x1;
        case (dm)
            2'd1: da = regs[dr] + xd;
            2'd2: da = pc + xd;
            2'd3: da = xd;
            default: da = 16'h0000;
        endcase
        if (dm == 2'd0) begin
            dv = regs[dr]; dm_exp = 1'b0; cd = 0;
        end else begin
            dv = memf(da); dm_exp = 1'b1; cd = 3; fetch++;
        end
        lat = 1 + cs + cd + stall * fetch;

        @(negedge clk);
        start = 1'b1; src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (glitch && n == 1) begin
                start = 1'b1; src_mode = 3'd0; src_reg = 4'd1; dst_mode = 2'd0; dst_reg = 4'd2;
            end else begin
                start = 1'b0;
            end
        end while (!done && n < 60);
        start = 1'b0;

        check((stall > 0) ? "R8 latency" : (glitch ? "R10 latency" : "R7 latency"),
              16'(n), 16'(lat));
        check({stag, " src_val"}, src_val, sv);
        check((fetch == 2) ? "R6 dst_val" : "R5 dst_val", dst_val, dv);
        check("R5 dst_addr", dst_addr, da);
        check("R5 dst_mem", {15'd0, dst_mem}, {15'd0, dm_exp});
        if (sm == 3'd5) begin
            check("R3 write count", 16'(wr_count - wr0), 16'd1);
            check("R3 write index", {12'd0, wr_idx_seen}, {12'd0, sr});
            check("R3 write data", wr_data_seen, regs[sr] + 16'd2);
        end else begin
            check("R3 no write", 16'(wr_count - wr0), 16'd0);
        end
        @(negedge clk);
        check("R9 done one cycle", {15'd0, done}, 16'd0);
        check("R9 src held", src_val, sv);
    endtask

    task automatic test_reset;
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 ext_req", {15'd0, ext_req}, 16'd0);
        check("R1 mem_rd", {15'd0, mem_rd}, 16'd0);
        check("R1 reg_wr", {15'd0, reg_wr}, 16'd0);
        check("R1 src_val", src_val, 16'd0);
    endtask

    task automatic test_all_pairs;
        for (int s = 0; s < 7; s++) begin
            for (int d = 0; d < 4; d++) begin
                load_regs(s * 4 + d);
                run_op(3'(s), 4'(3 + s), 2'(d), 4'(10 + d),
                       16'h0040 + 16'(s * 'h101) + 16'(d),
                       16'h0300 + 16'(d * 'h11) + 16'(s), 0, 1'b0);
            end
        end
    endtask

    task automatic test_stated_latencies;
        load_regs(40);
        run_op(3'd1, 4'd4, 2'd1, 4'd5, 16'h0010, 16'h0020, 0, 1'b0); // R7: 6 cycles
        run_op(3'd0, 4'd6, 2'd3, 4'd7, 16'h1234, 16'h0000, 0, 1'b0); // R7: 4 cycles
        run_op(3'd3, 4'd8, 2'd0, 4'd9, 16'h2468, 16'h0000, 0, 1'b0); // R7: 3 cycles
        run_op(3'd7, 4'd1, 2'd0, 4'd2, 16'h0000, 16'h0000, 0, 1'b0); // R2: code 7 as register
    endtask

    task automatic test_order_and_inc;
        load_regs(50);
        run_op(3'd2, 4'd3, 2'd2, 4'd4, 16'h0102, 16'h0A0B, 0, 1'b0); // R6
        run_op(3'd6, 4'd0, 2'd1, 4'd2, 16'hBEEF, 16'h0044, 0, 1'b0); // R6 R4
        run_op(3'd5, 4'd1, 2'd2, 4'd6, 16'h0080, 16'h0000, 0, 1'b0); // R3
    endtask

    task automatic test_stall;
        load_regs(60);
        run_op(3'd1, 4'd4, 2'd1, 4'd5, 16'h0010, 16'h0020, 3, 1'b0); // R8: 12 cycles
        run_op(3'd6, 4'd4, 2'd0, 4'd5, 16'h5555, 16'h0000, 1, 1'b0); // R8: 3 cycles
    endtask

    task automatic test_busy_start;
        load_regs(70);
        run_op(3'd1, 4'd7, 2'd3, 4'd8, 16'h0066, 16'h0777, 0, 1'b1); // R10
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 256; i++) ext_words[i] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_all_pairs();
        test_stated_latencies();
        test_order_and_inc();
        test_stall();
        test_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule